// File: doc/BRIEF.md
# Split Unsigned Multiplier on a Signed Core

This block multiplies two 18-bit unsigned operands and returns their full 36-bit unsigned product one clock later. A two's-complement 18x18 multiplier is correct for unsigned data only while both operand sign bits are zero. The block therefore never gives the signed core a wide operand. The core receives only the low 17 bits of each operand, each padded with a zero on top. The two top bits are each folded in as a single-bit partial product. A single-bit partial product is a plain AND of that bit with the other operand.

Let the operands be A and B. The result is the sum of three terms. The first is the core product of the low parts at weight 1. The second is A's top bit ANDed with the low 17 bits of B. The third is B's top bit ANDed with all 18 bits of A. The second and third terms are shifted left by 17 places. A single three-input addition combines all three terms. The sum is captured in a register together with a valid flag.

A producer presents operands with `in_valid` high for one cycle. The product appears on `prod_out` in the next cycle, together with `out_valid`. While `in_valid` is low, the product register keeps its last value.

Top module: `umul_split`

## Requirements
- R1: When `in_valid` is high at a rising edge, `prod_out` after that edge equals the exact unsigned product of `a_in` and `b_in`. The product is 36 bits wide and has no truncation, up to (2^18-1)^2 = 0xFFFF80001.
- R2: `out_valid` after each rising edge equals the value of `in_valid` at that edge. It is a one-cycle delay.
- R3: When `rst_n` is low at a rising edge, `prod_out` becomes 0 and `out_valid` becomes 0 after that edge. This takes priority over `in_valid`.
- R4: When `in_valid` is low at a rising edge, `prod_out` keeps its previous value, whatever is on `a_in` and `b_in`.
- R5: When an operand has bit 17 (its top bit) set, its extra weight of 2^17 is included in the product. This holds for 2^17, 2^17+1 and 2^18-1 on either or both operands.
- R6: The signed core only ever receives non-negative operands, because the sign bit of both core inputs is always 0. A single-bit partial product is zero whenever its selecting top bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands on `a_in`/`b_in` are to be multiplied |
| a_in | input | 18 | Unsigned operand A |
| b_in | input | 18 | Unsigned operand B |
| out_valid | output | 1 | `prod_out` holds a product computed in the previous cycle |
| prod_out | output | 36 | Registered unsigned product |

## Verification
The bench sweeps every pairing of a corner set for each operand. The set contains 0, 1, 2^17-1, 2^17, 2^17+1, 2^18-1 and an alternating bit pattern. Pairs with both top bits clear test the core path alone. Pairs with one top bit set isolate each single-bit term and its shift. Pairs with both top bits set test the cross term and the carry into bit 35. Several thousand random operand pairs then cover ordinary carry chains. Idle cycles with changing operands show that the product holds. A reset issued in the middle of a run shows that reset overrides a pending valid.

// File: rtl/umul_pkg.sv
// Package: shared sizing for the split unsigned multiplier.
// Assumes the operand width is at least 2 so that a top bit and a low part exist.
package umul_pkg;
    parameter int unsigned UMUL_OP_W = 18;
endpackage

// File: rtl/umul_signed_core.sv
// Module: umul_signed_core
// What it does: a two's-complement multiplier of CORE_W x CORE_W operands that gives a 2*CORE_W result.
// Assumes: the caller keeps both sign bits at 0 when it wants an unsigned result.
module umul_signed_core #(
    parameter int unsigned CORE_W = 18,
    localparam int unsigned RES_W = 2 * CORE_W
) (
    input  logic signed [CORE_W-1:0] x_in,
    input  logic signed [CORE_W-1:0] y_in,
    output logic signed [RES_W-1:0]  p_out
);
    logic signed [RES_W-1:0] x_ext;
    logic signed [RES_W-1:0] y_ext;

    // Sign-extend both factors to the result width, then multiply.
    always_comb begin
        x_ext = RES_W'(x_in);
        y_ext = RES_W'(y_in);
        p_out = x_ext * y_ext;
    end
endmodule

// File: rtl/umul_bit_term.sv
// Module: umul_bit_term
// What it does: multiplies an operand by one selecting bit with an AND gate per bit position.
// Assumes: the selecting bit is a plain 0/1 control, and no multiplier resource is needed.
module umul_bit_term #(
    parameter int unsigned TERM_W = 17
) (
    input  logic              sel_bit,
    input  logic [TERM_W-1:0] opnd,
    output logic [TERM_W-1:0] term
);
    // One AND gate per operand bit.
    for (genvar gi = 0; gi < TERM_W; gi++) begin : g_and
        assign term[gi] = sel_bit & opnd[gi];
    end
endmodule

// File: rtl/umul_sum3.sv
// Module: umul_sum3
// What it does: adds the core product at weight 1 and two single-bit terms, each shifted left by SHIFT.
// Assumes: the core product is non-negative, so its bits can be read as an unsigned value.
module umul_sum3 #(
    parameter int unsigned SUM_W = 36,
    parameter int unsigned T1_W  = 17,
    parameter int unsigned T2_W  = 18,
    parameter int unsigned SHIFT = 17
) (
    input  logic [SUM_W-1:0] core_prod,
    input  logic [T1_W-1:0]  term_a,
    input  logic [T2_W-1:0]  term_b,
    output logic [SUM_W-1:0] sum_out
);
    logic [SUM_W-1:0] ta_al;
    logic [SUM_W-1:0] tb_al;

    // Align both single-bit terms to their weight, then form the three-input sum.
    always_comb begin
        ta_al   = SUM_W'(term_a) << SHIFT;
        tb_al   = SUM_W'(term_b) << SHIFT;
        sum_out = core_prod + ta_al + tb_al;
    end
endmodule

// File: rtl/umul_split.sv
// Module: umul_split (top)
// What it does: a registered OP_W x OP_W unsigned multiplier.
//   The low parts go through the signed core, the top bits go through AND terms, and the three pieces are summed.
// Assumes: synchronous active-low reset, and the product holds while no valid input arrives.
module umul_split #(
    parameter int unsigned OP_W = umul_pkg::UMUL_OP_W,
    localparam int unsigned LOW_W  = OP_W - 1,
    localparam int unsigned PROD_W = 2 * OP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   a_in,
    input  logic [OP_W-1:0]   b_in,
    output logic              out_valid,
    output logic [PROD_W-1:0] prod_out
);
    logic signed [OP_W-1:0]   core_x;
    logic signed [OP_W-1:0]   core_y;
    logic signed [PROD_W-1:0] core_p;
    logic [LOW_W-1:0]         term_a;
    logic [OP_W-1:0]          term_b;
    logic [PROD_W-1:0]        sum_nx;

    // Zero-extend the low parts so that the signed core only sees non-negative values.
    always_comb begin
        core_x = {1'b0, a_in[LOW_W-1:0]};
        core_y = {1'b0, b_in[LOW_W-1:0]};
    end

    umul_signed_core #(.CORE_W(OP_W)) u_core (
        .x_in  (core_x),
        .y_in  (core_y),
        .p_out (core_p)
    );

    umul_bit_term #(.TERM_W(LOW_W)) u_term_a (
        .sel_bit (a_in[OP_W-1]),
        .opnd    (b_in[LOW_W-1:0]),
        .term    (term_a)
    );

    umul_bit_term #(.TERM_W(OP_W)) u_term_b (
        .sel_bit (b_in[OP_W-1]),
        .opnd    (a_in),
        .term    (term_b)
    );

    umul_sum3 #(
        .SUM_W (PROD_W),
        .T1_W  (LOW_W),
        .T2_W  (OP_W),
        .SHIFT (LOW_W)
    ) u_sum (
        .core_prod (core_p),
        .term_a    (term_a),
        .term_b    (term_b),
        .sum_out   (sum_nx)
    );

    // Output register: clears on reset, loads on a valid input, otherwise holds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_out  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                prod_out <= sum_nx;
            end
        end
    end
endmodule

// File: rtl/umul_split_chk.sv
// Module: umul_split_chk
// What it does: property checks for umul_split. It is attached to every instance through the bind statement below.
module umul_split_chk #(
    parameter int unsigned OP_W = 18,
    localparam int unsigned LOW_W  = OP_W - 1,
    localparam int unsigned PROD_W = 2 * OP_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [OP_W-1:0]   a_in,
    input logic [OP_W-1:0]   b_in,
    input logic              out_valid,
    input logic [PROD_W-1:0] prod_out,
    input logic [OP_W-1:0]   core_x,
    input logic [OP_W-1:0]   core_y,
    input logic [LOW_W-1:0]  term_a,
    input logic [OP_W-1:0]   term_b
);
    // R1: the registered product matches a wide reference multiply.
    p_exact_product_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> prod_out == (PROD_W'($past(a_in)) * PROD_W'($past(b_in))));

    // R2: out_valid is in_valid delayed by one cycle.
    p_valid_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3: reset clears both outputs.
    p_reset_clear_r3: assert property (@(posedge clk)
        !rst_n |=> (prod_out == '0) && !out_valid);

    // R4: with no valid input, the product holds.
    p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(prod_out));

    // R6: the core sees non-negative inputs, and each AND term is zero when its selecting bit is clear.
    p_core_nonneg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !core_x[OP_W-1] && !core_y[OP_W-1]);
    p_term_a_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !a_in[OP_W-1] |-> term_a == '0);
    p_term_b_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !b_in[OP_W-1] |-> term_b == '0);
endmodule

bind umul_split umul_split_chk #(.OP_W(OP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .a_in      (a_in),
    .b_in      (b_in),
    .out_valid (out_valid),
    .prod_out  (prod_out),
    .core_x    (core_x),
    .core_y    (core_y),
    .term_a    (term_a),
    .term_b    (term_b)
);

// File: tb/umul_split_tb.sv
// Bench for umul_split: a full sweep over corner pairs, a random sweep, and idle and reset checks.
module umul_split_tb;
    localparam int unsigned OW = 18;
    localparam int unsigned PW = 36;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [OW-1:0] a_in = '0;
    logic [OW-1:0] b_in = '0;
    logic          out_valid;
    logic [PW-1:0] prod_out;

    int checks = 0;
    int errors = 0;
    logic [PW-1:0] last_prod;

    always #5 clk = ~clk;

    umul_split u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .a_in      (a_in),
        .b_in      (b_in),
        .out_valid (out_valid),
        .prod_out  (prod_out)
    );

    function automatic logic [PW-1:0] ref_mul(logic [OW-1:0] x, logic [OW-1:0] y);
        longint unsigned xx, yy;
        xx = longint'(x);
        yy = longint'(y);
        return PW'(xx * yy);
    endfunction

    task automatic check(string req, logic [PW-1:0] act, logic [PW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one valid operand pair, then check the result after the capturing edge.
    task automatic run_pair(string req, logic [OW-1:0] x, logic [OW-1:0] y);
        @(negedge clk);
        a_in = x; b_in = y; in_valid = 1'b1;
        @(negedge clk);
        check(req, prod_out, ref_mul(x, y));
        check("R2", PW'(out_valid), PW'(1));
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [OW-1:0] corners [7];
        corners[0] = 18'd0;
        corners[1] = 18'd1;
        corners[2] = 18'h1FFFF;
        corners[3] = 18'h20000;
        corners[4] = 18'h20001;
        corners[5] = 18'h3FFFF;
        corners[6] = 18'h2AAAA;

        // R3: reset state.
        in_valid = 1'b1; a_in = 18'h3FFFF; b_in = 18'h3FFFF;
        repeat (3) @(negedge clk);
        check("R3", prod_out, '0);
        check("R3", PW'(out_valid), '0);
        rst_n = 1'b1;
        in_valid = 1'b0;

        // R1/R5: all corner pairs.
        for (int i = 0; i < 7; i++) begin
            for (int j = 0; j < 7; j++) begin
                if (corners[i][OW-1] || corners[j][OW-1])
                    run_pair("R5", corners[i], corners[j]);
                else
                    run_pair("R1", corners[i], corners[j]);
            end
        end

        // R5: the widest product reaches bit 35.
        run_pair("R5", 18'h3FFFF, 18'h3FFFF);
        check("R5", prod_out, 36'hFFFF80001);

        // R4/R2: while idle, the operands change and the product holds.
        last_prod = prod_out;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            in_valid = 1'b0; a_in = 18'(k * 977 + 5); b_in = 18'(k * 3001 + 11);
            @(negedge clk);
            check("R4", prod_out, last_prod);
            check("R2", PW'(out_valid), '0);
        end

        // R1: random operand pairs.
        for (int n = 0; n < 3000; n++) begin
            run_pair("R1", 18'($urandom), 18'($urandom));
        end

        // R3: reset in the middle of a run overrides a pending valid.
        @(negedge clk);
        a_in = 18'h12345; b_in = 18'h2F00F; in_valid = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        check("R3", prod_out, '0);
        check("R3", PW'(out_valid), '0);
        rst_n = 1'b1;
        run_pair("R1", 18'h12345, 18'h2F00F);

        @(negedge clk);
        in_valid = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule